// File: doc/BRIEF.md
# Coprocessor Thread Launch Sequencer

This block prepares and starts a service thread on a small 16-bit RISC coprocessor. When a launch request arrives with a channel number and that channel's interrupt priority, the sequencer computes the address of the channel's vector entry from a relocatable vector base. It then reads the two 16-bit words of that entry over a simple memory read port. The first word becomes the program counter. The second word is preloaded into general register 1 as the thread's data pointer. General register 7 is preloaded with one of two stack pointer initial values, chosen by the priority band of the channel. The block then raises a one-cycle start pulse to the core.

The block also holds the core's register file. It has eight 16-bit registers, and register 0 is hardwired to zero. The core reads the registers through a read port and writes them through a write port. Registers 2 to 6 and the condition flags are not set up at launch.

Launch requests use a valid/ready handshake. A request is taken on a cycle where `launch_valid` and `launch_ready` are both high. `launch_ready` is high only while the sequencer is idle, so the requester must hold its request until it is taken. The memory read port also uses valid/ready. `mem_rd_valid` stays high, with a constant address, until the memory answers with `mem_rd_ready`. The data on `mem_rd_data` is taken on that same cycle. The memory may stall for any number of cycles.

Top module: `thread_launcher`

## Requirements
- R1: Register 0 always reads 0x0000, and a core write to index 0 leaves it reading 0x0000.
- R2: A core write to a register with index 1 to 7 is read back from the read port after the next clock edge.
- R3: The vector entry lies at vector base + 4 × channel, modulo 2^16. The first read goes to that address and the second read goes to that address + 2, also modulo 2^16.
- R4: When the start pulse is seen, the program counter holds the first vector word and register 1 holds the second vector word.
- R5: At start, register 7 holds the upper-band stack value if the priority is 4 to 7, and the lower-band stack value if the priority is 1 to 3.
- R6: A request with priority 0 is consumed but otherwise ignored. No memory read, no start pulse, and no change to the program counter or to registers 1 and 7 follow from it.
- R7: From the edge that takes a request until the start pulse has been issued, `busy` is high and `launch_ready` is low. Requests offered in that window are not taken.
- R8: While a read is waiting for `mem_rd_ready`, `mem_rd_valid` stays high and `mem_rd_addr` stays constant.
- R9: `start` is high for exactly one cycle. It rises 4 clock edges after the accepting edge, plus one edge for each wait cycle of the memory.
- R10: After reset, the program counter is 0x0000, `busy` is low, `launch_ready` is high and `start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Sequencer can take a request (idle) |
| launch_chan | input | 7 | Channel number of the request |
| launch_prio | input | 3 | Interrupt priority of the channel (0 = none) |
| vec_base | input | 16 | Vector table base address |
| stack_hi | input | 16 | Stack initial value for priorities 4 to 7 |
| stack_lo | input | 16 | Stack initial value for priorities 1 to 3 |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_addr | output | 16 | Byte address of the read |
| mem_rd_ready | input | 1 | Memory returns data this cycle |
| mem_rd_data | input | 16 | Read data |
| pc | output | 16 | Program counter handed to the core |
| start | output | 1 | One-cycle thread start pulse |
| busy | output | 1 | A launch is in progress |
| rf_we | input | 1 | Core register write enable |
| rf_waddr | input | 3 | Core register write index |
| rf_wdata | input | 16 | Core register write data |
| rf_raddr | input | 3 | Core register read index |
| rf_rdata | output | 16 | Core register read data (combinational) |

## Verification
With a memory that answers at once, `busy` is high one edge after a request is accepted, and `start` is high four edges after it. Each wait cycle the bench memory inserts on each of the two reads adds one edge. The bench counts edges from the accepting edge until it first sees `start`, and compares that count with 4 plus the total number of wait cycles. It then samples `pc` and reads registers 1 and 7 in the same cycle as the pulse, because the preload lands on the edge that raises `start`. All outputs are sampled at the falling edge of the clock. Register reads are combinational, so a value written by the core is checked half a cycle after the edge that writes it.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FETCH_PC = 3'd1,
    ST_FETCH_DP = 3'd2,
    ST_LOAD     = 3'd3,
    ST_START    = 3'd4
  } tl_state_t;
endpackage

// File: rtl/tl_regfile.sv
module tl_regfile #(
  parameter int NREG   = 8,
  parameter int DW     = 16,
  parameter int DP_IDX = 1,
  parameter int SP_IDX = 7,
  localparam int AW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          pre_en,
  input  logic [DW-1:0] pre_dp,
  input  logic [DW-1:0] pre_sp,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [NREG];

  // index 0 is a constant, never a storage element
  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic pre_hit;
    logic [DW-1:0] pre_val;
    if (i == DP_IDX) begin : g_dp
      assign pre_hit = pre_en;
      assign pre_val = pre_dp;
    end else if (i == SP_IDX) begin : g_sp
      assign pre_hit = pre_en;
      assign pre_val = pre_sp;
    end else begin : g_gp
      assign pre_hit = 1'b0;
      assign pre_val = '0;
    end
    // preload from the sequencer outranks a core write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (pre_hit)
        regs[i] <= pre_val;
      else if (we && (waddr == AW'(i)))
        regs[i] <= wdata;
    end
  end

  assign rdata = regs[raddr];

  a_r1_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr == '0) |-> (rdata == '0));
endmodule

// File: rtl/tl_stack_sel.sv
module tl_stack_sel #(
  parameter int DW     = 16,
  parameter int PW     = 3,
  parameter int HI_MIN = 4
) (
  input  logic [PW-1:0] prio,
  input  logic [DW-1:0] stack_hi,
  input  logic [DW-1:0] stack_lo,
  output logic [DW-1:0] stack_sel
);
  always_comb begin
    if (prio >= PW'(HI_MIN)) stack_sel = stack_hi;
    else                     stack_sel = stack_lo;
  end
endmodule

// File: rtl/tl_fetch_fsm.sv
module tl_fetch_fsm
  import tl_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int CHAN_W = 7,
  parameter int PW     = 3,
  localparam int ENTRY_SHIFT = 2,
  localparam int WORD_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [PW-1:0]     req_prio,
  input  logic [AW-1:0]     vec_base,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ready,
  input  logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     pc_word,
  output logic [DW-1:0]     dp_word,
  output logic [PW-1:0]     prio_q,
  output logic              load_en,
  output logic              start,
  output logic              busy
);
  tl_state_t     state, state_nx;
  logic [AW-1:0] entry_addr;
  logic          take;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready && (req_prio != '0);
  assign busy      = (state != ST_IDLE);
  assign load_en   = (state == ST_LOAD);
  assign start     = (state == ST_START);
  assign rd_valid  = (state == ST_FETCH_PC) || (state == ST_FETCH_DP);
  assign rd_addr   = (state == ST_FETCH_DP) ? entry_addr + AW'(WORD_BYTES) : entry_addr;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (take) state_nx = ST_FETCH_PC;
      ST_FETCH_PC: if (rd_ready) state_nx = ST_FETCH_DP;
      ST_FETCH_DP: if (rd_ready) state_nx = ST_LOAD;
      ST_LOAD:     state_nx = ST_START;
      ST_START:    state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      entry_addr <= '0;
      prio_q     <= '0;
      pc_word    <= '0;
      dp_word    <= '0;
    end else begin
      state <= state_nx;
      if (take) begin
        entry_addr <= vec_base + (AW'(req_chan) << ENTRY_SHIFT);
        prio_q     <= req_prio;
      end
      if (state == ST_FETCH_PC && rd_ready) pc_word <= rd_data;
      if (state == ST_FETCH_DP && rd_ready) dp_word <= rd_data;
    end
  end

  a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  a_r7_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r6_prio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (prio_q != '0));
endmodule

// File: rtl/thread_launcher.sv
module thread_launcher #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int CHAN_W = 7,
  parameter int PW     = 3,
  parameter int NREG   = 8,
  localparam int RW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [CHAN_W-1:0] launch_chan,
  input  logic [PW-1:0]     launch_prio,
  input  logic [AW-1:0]     vec_base,
  input  logic [DW-1:0]     stack_hi,
  input  logic [DW-1:0]     stack_lo,
  output logic              mem_rd_valid,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [DW-1:0]     mem_rd_data,
  output logic [AW-1:0]     pc,
  output logic              start,
  output logic              busy,
  input  logic              rf_we,
  input  logic [RW-1:0]     rf_waddr,
  input  logic [DW-1:0]     rf_wdata,
  input  logic [RW-1:0]     rf_raddr,
  output logic [DW-1:0]     rf_rdata
);
  logic [DW-1:0] pc_word, dp_word, stack_val;
  logic [PW-1:0] prio_q;
  logic          load_en;

  tl_fetch_fsm #(.AW(AW), .DW(DW), .CHAN_W(CHAN_W), .PW(PW)) u_fsm (
    .clk, .rst_n,
    .req_valid(launch_valid), .req_ready(launch_ready),
    .req_chan(launch_chan), .req_prio(launch_prio), .vec_base,
    .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr),
    .rd_ready(mem_rd_ready), .rd_data(mem_rd_data),
    .pc_word, .dp_word, .prio_q, .load_en, .start, .busy
  );

  tl_stack_sel #(.DW(DW), .PW(PW)) u_sel (
    .prio(prio_q), .stack_hi, .stack_lo, .stack_sel(stack_val)
  );

  tl_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk, .rst_n,
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .pre_en(load_en), .pre_dp(dp_word), .pre_sp(stack_val),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (load_en) pc <= AW'(pc_word);
  end

  a_r4_pc_only_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(pc));
endmodule

// File: tb/sim_thread_launcher.sv
module sim_thread_launcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        launch_valid = 1'b0, launch_ready;
  logic [6:0]  launch_chan = '0;
  logic [2:0]  launch_prio = '0;
  logic [15:0] vec_base = '0, stack_hi = '0, stack_lo = '0;
  logic        mem_rd_valid, mem_rd_ready;
  logic [15:0] mem_rd_addr, mem_rd_data;
  logic [15:0] pc;
  logic        start, busy;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_waddr = '0, rf_raddr = '0;
  logic [15:0] rf_wdata = '0, rf_rdata;

  thread_launcher u0 (.*);

  int n_chk = 0, n_fail = 0;
  int wait_cfg = 0, wait_cnt = 0;
  int rd_seen = 0, start_seen = 0;
  logic [15:0] addr_log [2];

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return a * 16'd3 + 16'h1234;
  endfunction

  assign mem_rd_data  = mem_f(mem_rd_addr);
  assign mem_rd_ready = mem_rd_valid && (wait_cnt >= wait_cfg);

  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ready) begin
      if (rd_seen < 2) addr_log[rd_seen] <= mem_rd_addr;
      rd_seen  <= rd_seen + 1;
      wait_cnt <= 0;
    end else if (mem_rd_valid) wait_cnt <= wait_cnt + 1;
    if (start) start_seen <= start_seen + 1;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [2:0] idx, output logic [15:0] v);
    rf_raddr = idx;
    #1 v = rf_rdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 pc", pc, 16'h0000);
    check("R10 busy", {15'd0, busy}, 16'd0);
    check("R10 ready", {15'd0, launch_ready}, 16'd1);
    check("R10 start", {15'd0, start}, 16'd0);
  endtask

  task automatic t_regfile();
    logic [15:0] v;
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 3'd0; rf_wdata = 16'hBEEF;
    @(negedge clk);
    rf_waddr = 3'd3; rf_wdata = 16'h5A5A;
    @(negedge clk);
    rf_waddr = 3'd7; rf_wdata = 16'hC0DE;
    @(negedge clk);
    rf_we = 1'b0;
    read_reg(3'd0, v); check("R1 zero after write", v, 16'h0000);
    read_reg(3'd3, v); check("R2 reg3 readback", v, 16'h5A5A);
    read_reg(3'd7, v); check("R2 reg7 readback", v, 16'hC0DE);
  endtask

  // one launch, checking addresses, timing, pc, reg1 and reg7
  task automatic t_launch(input logic [6:0] ch, input logic [2:0] pr,
                          input logic [15:0] base, input int waits, input bit poke_busy);
    logic [15:0] ea, v;
    int cyc;
    ea = base + {7'd0, ch, 2'b00};
    vec_base = base; stack_hi = 16'hA000 + {13'd0, pr}; stack_lo = 16'h5000 + {13'd0, pr};
    wait_cfg = waits;
    @(negedge clk);
    rd_seen = 0; start_seen = 0;
    launch_valid = 1'b1; launch_chan = ch; launch_prio = pr;
    @(negedge clk);
    cyc = 1;
    check("R7 busy after accept", {15'd0, busy}, 16'd1);
    check("R7 ready low", {15'd0, launch_ready}, 16'd0);
    if (poke_busy) begin
      launch_chan = ch + 7'd5; launch_prio = 3'd2;
    end else launch_valid = 1'b0;
    while (!start && cyc < 50) begin
      @(negedge clk); cyc++;
    end
    launch_valid = 1'b0;
    check("R9 start latency", 16'(cyc), 16'(4 + 2 * waits));
    check("R3 first addr", addr_log[0], ea);
    check("R3 second addr", addr_log[1], ea + 16'd2);
    check("R4 pc", pc, mem_f(ea));
    read_reg(3'd1, v); check("R4 reg1", v, mem_f(ea + 16'd2));
    read_reg(3'd7, v);
    check("R5 reg7", v, (pr >= 3'd4) ? stack_hi : stack_lo);
    @(negedge clk);
    check("R9 start one cycle", {15'd0, start}, 16'd0);
    check("R7 idle after start", {15'd0, busy}, 16'd0);
    repeat (8) @(negedge clk);
    check("R7 no extra launch", 16'(start_seen), 16'd1);
  endtask

  task automatic t_prio_zero();
    logic [15:0] pc0, r1, r7, v;
    read_reg(3'd1, r1); read_reg(3'd7, r7); pc0 = pc;
    @(negedge clk);
    rd_seen = 0; start_seen = 0;
    launch_valid = 1'b1; launch_chan = 7'd9; launch_prio = 3'd0;
    vec_base = 16'h2000; stack_hi = 16'h1111; stack_lo = 16'h2222;
    @(negedge clk);
    launch_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 no start", 16'(start_seen), 16'd0);
    check("R6 no read", 16'(rd_seen), 16'd0);
    check("R6 pc kept", pc, pc0);
    read_reg(3'd1, v); check("R6 reg1 kept", v, r1);
    read_reg(3'd7, v); check("R6 reg7 kept", v, r7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regfile();
        t_launch(7'd3, 3'd6, 16'h4000, 0, 1'b0);
        t_launch(7'd10, 3'd2, 16'h8100, 2, 1'b0);
        t_launch(7'd1, 3'd4, 16'hFFFC, 1, 1'b1);   // wraps to 0x0000
        t_launch(7'd127, 3'd1, 16'hFE10, 3, 1'b0);
        t_prio_zero();
        t_launch(7'd0, 3'd7, 16'h0000, 0, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule